// File: doc/BRIEF.md
# Interrupt Message Acceptance Filter

This block sits between a system interrupt bus and one local interrupt controller. It looks at each incoming interrupt message and gives one verdict: accept, discard or retry. A message carries a destination-match flag, a delivery mode, a vector and a trigger mode. The destination match is decoded outside the block. The pending and in-service storage is also outside, and it reports back one busy bit per vector.

Messages with a direct delivery mode go to a core-side strobe and never take a queue slot. Queued messages are passed to the pending-request interface only when the slot for their vector is free. These are fixed mode, and lowest-priority mode after its focus and arbitration checks. Any other queued message is answered with retry or discard.

Every message is strobed for one cycle. Its verdict, and any core or pending-request pulse it causes, appears on the registered outputs in the following cycle.

Top module: `irq_accept_filter`

## Requirements
- R1: A `msg_valid_i` pulse produces exactly one `rsp_valid_o` pulse on the next cycle. A cycle without `msg_valid_i` produces no `rsp_valid_o` on the next cycle. `rsp_code_o` is 2'b00 for discard, 2'b01 for accept and 2'b10 for retry.
- R2: A message with `msg_dest_match_i` low is discarded. It raises neither `core_valid_o` nor `pend_valid_o`, whatever its mode or slot state.
- R3: A matching message with mode 3'b010, 3'b100, 3'b101, 3'b110 or 3'b111 is accepted. It raises `core_valid_o` with its mode, vector and trigger on the core outputs, and never raises `pend_valid_o`, whatever the slot, focus and retry inputs are.
- R4: A matching message with the unused mode 3'b011 is discarded with no core or pending pulse.
- R5: A matching fixed message (mode 3'b000) is accepted when `slot_busy_i[vector]` is 0. It then raises `pend_valid_o` with its vector and trigger. When the bit is 1, the message is answered with retry and no pending pulse.
- R6: For a lowest-priority message (mode 3'b001) with `focus_self_i` high: a busy slot gives retry. A free slot with `retry_posted_i` high gives discard. Otherwise the message is accepted with a pending pulse.
- R7: For a lowest-priority message with `focus_self_i` low and `focus_other_i` high, the message is discarded, even when its slot is busy or arbitration is won.
- R8: For a lowest-priority message with no focus: a busy slot gives retry. A free slot with `retry_posted_i` high gives discard. A lost arbitration (`arb_win_i` low) gives discard. Otherwise the message is accepted with a pending pulse.
- R9: When `focus_self_i` and `focus_other_i` are both high, the self-focus rules of R6 apply.
- R10: During and right after reset, `rsp_valid_o`, `core_valid_o` and `pend_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | One-cycle message strobe |
| msg_dest_match_i | input | 1 | Message is addressed to this controller |
| msg_mode_i | input | 3 | Delivery mode |
| msg_vector_i | input | VEC_W | Interrupt vector |
| msg_level_i | input | 1 | Trigger mode, 1 = level |
| retry_posted_i | input | 1 | A retry status was already posted for this message |
| focus_self_i | input | 1 | This controller is the focus for the vector |
| focus_other_i | input | 1 | Another controller is the focus |
| arb_win_i | input | 1 | This controller won lowest-priority arbitration |
| slot_busy_i | input | 2**VEC_W | Per-vector flag: no free queue slot |
| rsp_valid_o | output | 1 | Verdict strobe |
| rsp_code_o | output | 2 | Verdict code |
| core_valid_o | output | 1 | Direct delivery strobe to core |
| core_mode_o | output | 3 | Mode of the direct delivery |
| core_vector_o | output | VEC_W | Vector of the direct delivery |
| core_level_o | output | 1 | Trigger of the direct delivery |
| pend_valid_o | output | 1 | Pending-request strobe |
| pend_vector_o | output | VEC_W | Vector to queue |
| pend_level_o | output | 1 | Trigger of the queued request |

## Verification
The slot check and the focus/arbitration checks are evaluated in the same cycle, so their conflicts are set up on purpose. In one case a busy slot meets won arbitration. In another a free slot meets a posted retry. A third sets both focus flags at once. The outcome is judged against the priority order of R6 to R9. The bench also sends direct-mode messages while every slot is busy and a retry is posted. This shows that the queue conditions never reach the core path. Back-to-back messages check that each verdict belongs to its own message.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [2:0] {
    DM_FIXED   = 3'b000,
    DM_LOWPRI  = 3'b001,
    DM_SMI     = 3'b010,
    DM_UNUSED  = 3'b011,
    DM_NMI     = 3'b100,
    DM_INIT    = 3'b101,
    DM_STARTUP = 3'b110,
    DM_EXTINT  = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    RSP_DISCARD = 2'b00,
    RSP_ACCEPT  = 2'b01,
    RSP_RETRY   = 2'b10
  } rsp_e;

  typedef enum logic [1:0] {
    CLS_FIXED,
    CLS_LOWPRI,
    CLS_DIRECT,
    CLS_INVALID
  } cls_e;

  typedef struct packed {
    rsp_e code;
    logic to_core;
    logic to_pend;
  } verdict_t;

  localparam verdict_t VERDICT_DISCARD = '{code: RSP_DISCARD, to_core: 1'b0, to_pend: 1'b0};
  localparam verdict_t VERDICT_RETRY   = '{code: RSP_RETRY,   to_core: 1'b0, to_pend: 1'b0};
  localparam verdict_t VERDICT_QUEUE   = '{code: RSP_ACCEPT,  to_core: 1'b0, to_pend: 1'b1};
  localparam verdict_t VERDICT_DIRECT  = '{code: RSP_ACCEPT,  to_core: 1'b1, to_pend: 1'b0};

endpackage

// File: rtl/irq_mode_decode.sv
module irq_mode_decode
  import irq_accept_pkg::*;
(
  input  logic [2:0] mode_i,
  output cls_e       cls_o
);

  always_comb begin
    unique case (dmode_e'(mode_i))
      DM_FIXED:   cls_o = CLS_FIXED;
      DM_LOWPRI:  cls_o = CLS_LOWPRI;
      DM_SMI,
      DM_NMI,
      DM_INIT,
      DM_STARTUP,
      DM_EXTINT:  cls_o = CLS_DIRECT;
      default:    cls_o = CLS_INVALID;
    endcase
  end

endmodule

// File: rtl/irq_slot_lookup.sv
module irq_slot_lookup #(
  parameter int VEC_W = 8,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic [NUM_VEC-1:0] busy_i,
  input  logic [VEC_W-1:0]   vec_i,
  output logic               free_o
);

  logic [NUM_VEC-1:0] hit;

  // one-hot select of the busy flag, flat OR tree instead of a wide mux
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_hit
    assign hit[g] = busy_i[g] & (vec_i == VEC_W'(g));
  end

  assign free_o = ~|hit;

endmodule

// File: rtl/irq_lowpri_resolve.sv
module irq_lowpri_resolve
  import irq_accept_pkg::*;
(
  input  logic     slot_free_i,
  input  logic     retry_posted_i,
  input  logic     focus_self_i,
  input  logic     focus_other_i,
  input  logic     arb_win_i,
  output verdict_t verdict_o
);

  always_comb begin
    if (focus_self_i) begin
      if (!slot_free_i)        verdict_o = VERDICT_RETRY;
      else if (retry_posted_i) verdict_o = VERDICT_DISCARD;
      else                     verdict_o = VERDICT_QUEUE;
    end else if (focus_other_i) begin
      verdict_o = VERDICT_DISCARD;
    end else begin
      if (!slot_free_i)        verdict_o = VERDICT_RETRY;
      else if (retry_posted_i) verdict_o = VERDICT_DISCARD;
      else if (!arb_win_i)     verdict_o = VERDICT_DISCARD;
      else                     verdict_o = VERDICT_QUEUE;
    end
  end

endmodule

// File: rtl/irq_accept_filter.sv
module irq_accept_filter
  import irq_accept_pkg::*;
#(
  parameter int VEC_W = 8,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               msg_valid_i,
  input  logic               msg_dest_match_i,
  input  logic [2:0]         msg_mode_i,
  input  logic [VEC_W-1:0]   msg_vector_i,
  input  logic               msg_level_i,
  input  logic               retry_posted_i,
  input  logic               focus_self_i,
  input  logic               focus_other_i,
  input  logic               arb_win_i,
  input  logic [NUM_VEC-1:0] slot_busy_i,
  output logic               rsp_valid_o,
  output logic [1:0]         rsp_code_o,
  output logic               core_valid_o,
  output logic [2:0]         core_mode_o,
  output logic [VEC_W-1:0]   core_vector_o,
  output logic               core_level_o,
  output logic               pend_valid_o,
  output logic [VEC_W-1:0]   pend_vector_o,
  output logic               pend_level_o
);

  cls_e     cls;
  logic     slot_free;
  verdict_t lp_verdict;
  verdict_t verdict;

  irq_mode_decode i_mode_decode (
    .mode_i (msg_mode_i),
    .cls_o  (cls)
  );

  irq_slot_lookup #(.VEC_W(VEC_W)) i_slot_lookup (
    .busy_i (slot_busy_i),
    .vec_i  (msg_vector_i),
    .free_o (slot_free)
  );

  irq_lowpri_resolve i_lowpri_resolve (
    .slot_free_i    (slot_free),
    .retry_posted_i (retry_posted_i),
    .focus_self_i   (focus_self_i),
    .focus_other_i  (focus_other_i),
    .arb_win_i      (arb_win_i),
    .verdict_o      (lp_verdict)
  );

  always_comb begin
    if (!msg_dest_match_i) begin
      verdict = VERDICT_DISCARD;
    end else begin
      unique case (cls)
        CLS_DIRECT: verdict = VERDICT_DIRECT;
        CLS_FIXED:  verdict = slot_free ? VERDICT_QUEUE : VERDICT_RETRY;
        CLS_LOWPRI: verdict = lp_verdict;
        default:    verdict = VERDICT_DISCARD;
      endcase
    end
  end

  // strobes reset, payload held only when a message arrives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o  <= 1'b0;
      rsp_code_o   <= RSP_DISCARD;
      core_valid_o <= 1'b0;
      pend_valid_o <= 1'b0;
    end else begin
      rsp_valid_o  <= msg_valid_i;
      rsp_code_o   <= msg_valid_i ? verdict.code : RSP_DISCARD;
      core_valid_o <= msg_valid_i & verdict.to_core;
      pend_valid_o <= msg_valid_i & verdict.to_pend;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      core_mode_o   <= '0;
      core_vector_o <= '0;
      core_level_o  <= 1'b0;
    end else if (msg_valid_i && verdict.to_core) begin
      core_mode_o   <= msg_mode_i;
      core_vector_o <= msg_vector_i;
      core_level_o  <= msg_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_vector_o <= '0;
      pend_level_o  <= 1'b0;
    end else if (msg_valid_i && verdict.to_pend) begin
      pend_vector_o <= msg_vector_i;
      pend_level_o  <= msg_level_i;
    end
  end

endmodule

// File: rtl/irq_accept_filter_chk.sv
module irq_accept_filter_chk #(
  parameter int VEC_W = 8,
  localparam int NUM_VEC = 1 << VEC_W
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_i,
  input logic               msg_dest_match_i,
  input logic [2:0]         msg_mode_i,
  input logic [VEC_W-1:0]   msg_vector_i,
  input logic               focus_self_i,
  input logic               focus_other_i,
  input logic [NUM_VEC-1:0] slot_busy_i,
  input logic               rsp_valid_o,
  input logic [1:0]         rsp_code_o,
  input logic               core_valid_o,
  input logic               pend_valid_o,
  input logic [VEC_W-1:0]   pend_vector_o
);

  logic direct_mode;
  assign direct_mode = (msg_mode_i == 3'b010) || msg_mode_i[2];

  AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i |=> rsp_valid_o); // R1
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !msg_valid_i |=> !rsp_valid_o); // R1
  AST_DEST_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && !msg_dest_match_i |=> rsp_code_o == 2'b00 && !core_valid_o && !pend_valid_o); // R2
  AST_DIRECT_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_dest_match_i && direct_mode |=> core_valid_o && !pend_valid_o); // R3
  AST_SINGLE_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(core_valid_o && pend_valid_o)); // R3
  AST_UNUSED_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_dest_match_i && msg_mode_i == 3'b011 |=> rsp_code_o == 2'b00); // R4
  AST_FIXED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_dest_match_i && msg_mode_i == 3'b000 && slot_busy_i[msg_vector_i]
    |=> rsp_code_o == 2'b10 && !pend_valid_o); // R5
  AST_PEND_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> rsp_valid_o && rsp_code_o == 2'b01 && pend_vector_o == $past(msg_vector_i)); // R5
  AST_OTHER_FOCUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_i && msg_dest_match_i && msg_mode_i == 3'b001 && !focus_self_i && focus_other_i
    |=> rsp_code_o == 2'b00); // R7
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> !rsp_valid_o && !core_valid_o && !pend_valid_o); // R10

endmodule

bind irq_accept_filter irq_accept_filter_chk #(.VEC_W(VEC_W)) i_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .msg_valid_i      (msg_valid_i),
  .msg_dest_match_i (msg_dest_match_i),
  .msg_mode_i       (msg_mode_i),
  .msg_vector_i     (msg_vector_i),
  .focus_self_i     (focus_self_i),
  .focus_other_i    (focus_other_i),
  .slot_busy_i      (slot_busy_i),
  .rsp_valid_o      (rsp_valid_o),
  .rsp_code_o       (rsp_code_o),
  .core_valid_o     (core_valid_o),
  .pend_valid_o     (pend_valid_o),
  .pend_vector_o    (pend_vector_o)
);

// File: tb/test_irq_accept_filter.sv
module test_irq_accept_filter;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 8;
  localparam int NUM_VEC = 1 << VEC_W;
  localparam logic [1:0] DIS = 2'b00, ACC = 2'b01, RTY = 2'b10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic msg_valid = 1'b0, dest_match = 1'b0, level = 1'b0;
  logic [2:0] mode = '0;
  logic [VEC_W-1:0] vector = '0;
  logic retry_posted = 1'b0, focus_self = 1'b0, focus_other = 1'b0, arb_win = 1'b0;
  logic [NUM_VEC-1:0] slot_busy = '0;
  logic rsp_valid, core_valid, core_level, pend_valid, pend_level;
  logic [1:0] rsp_code;
  logic [2:0] core_mode;
  logic [VEC_W-1:0] core_vector, pend_vector;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_filter #(.VEC_W(VEC_W)) i_irq_accept_filter (
    .clk_i(clk), .rst_ni(rst_ni), .msg_valid_i(msg_valid), .msg_dest_match_i(dest_match),
    .msg_mode_i(mode), .msg_vector_i(vector), .msg_level_i(level),
    .retry_posted_i(retry_posted), .focus_self_i(focus_self), .focus_other_i(focus_other),
    .arb_win_i(arb_win), .slot_busy_i(slot_busy), .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code),
    .core_valid_o(core_valid), .core_mode_o(core_mode), .core_vector_o(core_vector),
    .core_level_o(core_level), .pend_valid_o(pend_valid), .pend_vector_o(pend_vector),
    .pend_level_o(pend_level)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, captured at the next rising edge, sampled one falling edge later
  task automatic send(input logic m, input logic [2:0] md, input logic [VEC_W-1:0] v,
                      input logic lv, input logic rp, input logic fs, input logic fo,
                      input logic aw);
    msg_valid = 1'b1; dest_match = m; mode = md; vector = v; level = lv;
    retry_posted = rp; focus_self = fs; focus_other = fo; arb_win = aw;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic expect_rsp(input string req, input logic [1:0] code, input logic core,
                            input logic pend, input logic [2:0] md, input logic [VEC_W-1:0] v,
                            input logic lv);
    check({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    check({req, " rsp_code"}, 32'(rsp_code), 32'(code));
    check({req, " core_valid"}, 32'(core_valid), 32'(core));
    check({req, " pend_valid"}, 32'(pend_valid), 32'(pend));
    if (core) begin
      check({req, " core_mode"}, 32'(core_mode), 32'(md));
      check({req, " core_vector"}, 32'(core_vector), 32'(v));
      check({req, " core_level"}, 32'(core_level), 32'(lv));
    end
    if (pend) begin
      check({req, " pend_vector"}, 32'(pend_vector), 32'(v));
      check({req, " pend_level"}, 32'(pend_level), 32'(lv));
    end
  endtask

  task automatic t_reset;
    check("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R10 core_valid", 32'(core_valid), 32'd0);
    check("R10 pend_valid", 32'(pend_valid), 32'd0);
  endtask

  task automatic t_timing;
    send(1, 3'b000, 8'h41, 0, 0, 0, 0, 0);
    expect_rsp("R1 first", ACC, 0, 1, 3'b000, 8'h41, 0);
    @(negedge clk);
    check("R1 idle no rsp", 32'(rsp_valid), 32'd0);
    check("R1 idle no pend", 32'(pend_valid), 32'd0);
    // back to back: each verdict belongs to its own message
    slot_busy[8'h42] = 1'b1;
    send(1, 3'b000, 8'h42, 0, 0, 0, 0, 0);
    expect_rsp("R1 b2b a", RTY, 0, 0, 3'b000, 8'h42, 0);
    send(1, 3'b000, 8'h43, 1, 0, 0, 0, 0);
    expect_rsp("R1 b2b b", ACC, 0, 1, 3'b000, 8'h43, 1);
    slot_busy[8'h42] = 1'b0;
  endtask

  task automatic t_dest_miss;
    slot_busy = '1;
    for (int md = 0; md < 8; md++) begin
      send(0, 3'(md), 8'h77, 1, 0, 1, 0, 1);
      expect_rsp("R2 miss", DIS, 0, 0, 3'(md), 8'h77, 1);
    end
    slot_busy = '0;
  endtask

  task automatic t_direct;
    logic [2:0] modes [5] = '{3'b010, 3'b100, 3'b101, 3'b110, 3'b111};
    slot_busy = '1;
    foreach (modes[i]) begin
      send(1, modes[i], 8'(8'h20 + i), i[0], 1, 0, 1, 0);
      expect_rsp("R3 direct", ACC, 1, 0, modes[i], 8'(8'h20 + i), i[0]);
    end
    slot_busy = '0;
  endtask

  task automatic t_unused;
    send(1, 3'b011, 8'h55, 0, 0, 1, 0, 1);
    expect_rsp("R4 unused", DIS, 0, 0, 3'b011, 8'h55, 0);
  endtask

  task automatic t_fixed;
    slot_busy[8'hF0] = 1'b1;
    send(1, 3'b000, 8'hF0, 1, 0, 0, 0, 0);
    expect_rsp("R5 busy", RTY, 0, 0, 3'b000, 8'hF0, 1);
    send(1, 3'b000, 8'hF1, 1, 1, 0, 1, 0); // neighbour free, focus inputs irrelevant
    expect_rsp("R5 free", ACC, 0, 1, 3'b000, 8'hF1, 1);
    send(1, 3'b000, 8'hFF, 0, 0, 0, 0, 0);
    expect_rsp("R5 top vec", ACC, 0, 1, 3'b000, 8'hFF, 0);
    slot_busy = '0;
  endtask

  task automatic t_focus_self;
    slot_busy[8'h30] = 1'b1;
    send(1, 3'b001, 8'h30, 0, 0, 1, 0, 1);
    expect_rsp("R6 busy", RTY, 0, 0, 3'b001, 8'h30, 0);
    send(1, 3'b001, 8'h31, 0, 1, 1, 0, 0);
    expect_rsp("R6 retry posted", DIS, 0, 0, 3'b001, 8'h31, 0);
    send(1, 3'b001, 8'h32, 1, 0, 1, 0, 0);
    expect_rsp("R6 accept", ACC, 0, 1, 3'b001, 8'h32, 1);
    slot_busy = '0;
  endtask

  task automatic t_focus_other;
    slot_busy[8'h60] = 1'b1;
    send(1, 3'b001, 8'h60, 0, 0, 0, 1, 1);
    expect_rsp("R7 busy", DIS, 0, 0, 3'b001, 8'h60, 0);
    send(1, 3'b001, 8'h61, 0, 0, 0, 1, 1);
    expect_rsp("R7 free win", DIS, 0, 0, 3'b001, 8'h61, 0);
    slot_busy = '0;
  endtask

  task automatic t_no_focus;
    slot_busy[8'h90] = 1'b1;
    send(1, 3'b001, 8'h90, 0, 0, 0, 0, 1);
    expect_rsp("R8 busy win", RTY, 0, 0, 3'b001, 8'h90, 0);
    send(1, 3'b001, 8'h91, 0, 1, 0, 0, 1);
    expect_rsp("R8 retry posted", DIS, 0, 0, 3'b001, 8'h91, 0);
    send(1, 3'b001, 8'h92, 0, 0, 0, 0, 0);
    expect_rsp("R8 lost", DIS, 0, 0, 3'b001, 8'h92, 0);
    send(1, 3'b001, 8'h93, 1, 0, 0, 0, 1);
    expect_rsp("R8 win", ACC, 0, 1, 3'b001, 8'h93, 1);
    slot_busy = '0;
  endtask

  task automatic t_both_focus;
    send(1, 3'b001, 8'hA5, 1, 0, 1, 1, 0);
    expect_rsp("R9 both accept", ACC, 0, 1, 3'b001, 8'hA5, 1);
    slot_busy[8'hA6] = 1'b1;
    send(1, 3'b001, 8'hA6, 0, 0, 1, 1, 0);
    expect_rsp("R9 both busy", RTY, 0, 0, 3'b001, 8'hA6, 0);
    slot_busy = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_timing();
    t_dest_miss();
    t_direct();
    t_unused();
    t_fixed();
    t_focus_self();
    t_focus_other();
    t_no_focus();
    t_both_focus();
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule